// File: doc/BRIEF.md
# Serial Motor-Bridge Configuration Loader

This block receives configuration frames for a two-bridge motor controller over a three-wire, write-only serial link. The link has a shift clock, a data line and a strobe. Each 16-bit frame names its own destination in its two top bits. The remaining fourteen bits carry parameter fields. When the strobe rises after a correctly sized frame, the frame is copied into the addressed holding word. The decoded fields for each bridge are then presented as plain, always-valid control outputs.

The serial pins are asynchronous to the block clock. They are oversampled through synchronizers, and their edges are detected in the block clock domain. The serial pins therefore have to toggle slower than the block clock, at no more than a quarter of its rate. The link has no back-pressure and no acknowledge. A frame that arrives while the block is busy clearing is lost, and the sender learns nothing about it.

Four independent conditions return every holding word to its default:
- power-on reset
- a low level on the sleep pin
- an undervoltage flag
- an overcurrent fault flag

A pending partial frame is dropped at the same time. Within the timing words, bits 13:12 are accepted on the link and thrown away. In the misc word, bits 13:2 are also thrown away.

Top module: `motor_cfg_port`

## Requirements
- R1: A frame is 16 bits, shifted in MSB first, one bit per rising edge of `ser_clk` while `ser_stb` is low.
- R2: When `ser_stb` rises after exactly 16 shift edges, the frame is committed. The outputs show the new values no more than 6 block clock cycles after that rise, and never before it.
- R3: Frame bits 15:14 select the destination word: 00 is the bridge-1 timing word, 01 is the bridge-2 timing word, 10 is the control word and 11 is the misc word. A commit changes only the outputs fed by the addressed word.
- R4: Timing word layout, frame bits: blank code [1:0], off-time code [6:2], fast-decay code [10:7], sync-rectification passive flag [11].
- R5: Control word layout: bridge 2 uses internal slow-decay [0], external slow-decay [1], phase [2] and DAC code [6:3]. Bridge 1 uses the same fields at [7], [8], [9] and [13:10]. Misc word layout: thermal-route flag [0], charge-pump-off flag [1].
- R6: On `rst_n` low, every field resets to zero, except that the off-time code of both bridges resets to 16 (MSB set).
- R7: A low `sleep_n` restores the defaults of R6 and discards any partially shifted frame.
- R8: A high `uvlo` restores the defaults of R6 on the following clock edge.
- R9: A high `ocp_fault` restores the defaults of R6 on the following clock edge.
- R10: A frame with fewer or more than 16 shift edges before the strobe rise changes no output.
- R11: Shift-clock edges while `ser_stb` is high are ignored and do not count toward the 16.
- R12: Outputs hold their values in every cycle that carries neither a commit nor a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| sleep_n | input | 1 | Standby request, active low; clears configuration |
| uvlo | input | 1 | Undervoltage flag, clock-synchronous; clears configuration |
| ocp_fault | input | 1 | Latched overcurrent flag, clock-synchronous; clears configuration |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_data | input | 1 | Serial data, MSB first |
| ser_stb | input | 1 | Serial strobe; rising edge commits |
| blank_time | output | 4 | Blank code per bridge, [1:0] bridge 1, [3:2] bridge 2 |
| off_time | output | 10 | Off-time code per bridge, 5 bits each |
| fast_decay | output | 8 | Fast-decay code per bridge, 4 bits each |
| sync_passive | output | 2 | Sync-rectification passive flag per bridge |
| int_slow | output | 2 | Internal-PWM slow-decay select per bridge |
| ext_slow | output | 2 | External-PWM slow-decay select per bridge |
| phase | output | 2 | Phase per bridge |
| dac_code | output | 8 | Current DAC code per bridge, 4 bits each |
| tmon_route | output | 1 | Thermal-route flag |
| cpump_off | output | 1 | Charge-pump-off flag |

## Verification
Some properties are checked in every cycle. The clear conditions (sleep, undervoltage and overcurrent) must leave every field at its default one edge later. Outputs must not move without a commit. A commit to any word other than the control word must leave the phase, decay and DAC outputs untouched.

Other behaviour can only be shown by the bench's frame sequences:
- MSB-first bit ordering and each field's position.
- The exact 16-edge gate, tested with short frames, long frames and edges clocked under a high strobe.
- Dropping a partial frame across a sleep pulse.
- The commit latency bound.

// File: rtl/motor_cfg_pkg.sv
package motor_cfg_pkg;
  localparam int FRAME_W    = 16;
  localparam int ADDR_W     = 2;
  localparam int PAYLOAD_W  = FRAME_W - ADDR_W;
  localparam int NUM_BR     = 2;
  localparam int TIMING_W   = 12;
  localparam int BR_CTRL_W  = 7;
  localparam int CTRL_W     = NUM_BR * BR_CTRL_W;
  localparam int MISC_W     = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADR_TIMING_B1 = 2'd0,
    ADR_TIMING_B2 = 2'd1,
    ADR_CTRL      = 2'd2,
    ADR_MISC      = 2'd3
  } word_addr_e;

  // Packed order follows frame bit order: sync[11], fast[10:7], off[6:2], blank[1:0].
  typedef struct packed {
    logic       sync_passive;
    logic [3:0] fast_decay;
    logic [4:0] off_time;
    logic [1:0] blank;
  } timing_t;

  // dac[6:3], phase[2], ext_slow[1], int_slow[0] within a bridge slice.
  typedef struct packed {
    logic [3:0] dac;
    logic       phase;
    logic       ext_slow;
    logic       int_slow;
  } bctrl_t;

  localparam logic [TIMING_W-1:0] TIMING_DEFAULT = 12'h040;
  localparam logic [CTRL_W-1:0]   CTRL_DEFAULT   = '0;
  localparam logic [MISC_W-1:0]   MISC_DEFAULT   = '0;
endpackage

// File: rtl/motor_cfg_sync.sv
module motor_cfg_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/motor_cfg_shift.sv
module motor_cfg_shift
  import motor_cfg_pkg::*;
#(
  parameter int FW = FRAME_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 sclk_s,
  input  logic                 sdat_s,
  input  logic                 stb_s,
  output logic                 commit_v,
  output logic [ADDR_W-1:0]    commit_addr,
  output logic [PAYLOAD_W-1:0] commit_data
);
  localparam int CNT_W = $clog2(FW + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FW);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FW + 1);

  logic          sclk_q, stb_q;
  logic          sclk_rise, stb_rise;
  logic [FW-1:0] shreg;
  logic [CNT_W-1:0] cnt;

  // Edge detection in the block clock domain.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      stb_q  <= 1'b0;
    end else begin
      sclk_q <= sclk_s;
      stb_q  <= stb_s;
    end
  end

  assign sclk_rise = sclk_s & ~sclk_q;
  assign stb_rise  = stb_s & ~stb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg       <= '0;
      cnt         <= '0;
      commit_v    <= 1'b0;
      commit_addr <= '0;
      commit_data <= '0;
    end else if (clr) begin
      shreg    <= '0;
      cnt      <= '0;
      commit_v <= 1'b0;
    end else begin
      commit_v <= 1'b0;
      if (stb_rise) begin
        if (cnt == CNT_FULL) begin
          commit_v    <= 1'b1;
          commit_addr <= shreg[FW-1 -: ADDR_W];
          commit_data <= shreg[PAYLOAD_W-1:0];
        end
        cnt <= '0;
      end else if (sclk_rise && !stb_s) begin
        shreg <= {shreg[FW-2:0], sdat_s};
        if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/motor_cfg_regs.sv
module motor_cfg_regs
  import motor_cfg_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   wr_v,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [PAYLOAD_W-1:0]   wr_data,
  output timing_t [NUM_BR-1:0]   timing_o,
  output bctrl_t  [NUM_BR-1:0]   bctrl_o,
  output logic    [MISC_W-1:0]   misc_o
);
  logic [CTRL_W-1:0] ctrl_r;
  logic [MISC_W-1:0] misc_r;

  // One timing word per bridge; word address equals bridge index.
  for (genvar i = 0; i < NUM_BR; i++) begin : g_timing
    logic [TIMING_W-1:0] timing_r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 timing_r <= TIMING_DEFAULT;
      else if (clr)                               timing_r <= TIMING_DEFAULT;
      else if (wr_v && wr_addr == ADDR_W'(i))     timing_r <= wr_data[TIMING_W-1:0];
    end
    assign timing_o[i] = timing_t'(timing_r);
    // Bridge 1 sits in the upper slice of the control word.
    assign bctrl_o[i]  = bctrl_t'(ctrl_r[(NUM_BR-1-i)*BR_CTRL_W +: BR_CTRL_W]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_r <= CTRL_DEFAULT;
      misc_r <= MISC_DEFAULT;
    end else if (clr) begin
      ctrl_r <= CTRL_DEFAULT;
      misc_r <= MISC_DEFAULT;
    end else if (wr_v) begin
      if (wr_addr == ADR_CTRL) ctrl_r <= wr_data[CTRL_W-1:0];
      if (wr_addr == ADR_MISC) misc_r <= wr_data[MISC_W-1:0];
    end
  end

  assign misc_o = misc_r;
endmodule

// File: rtl/motor_cfg_port.sv
module motor_cfg_port
  import motor_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sleep_n,
  input  logic         uvlo,
  input  logic         ocp_fault,
  input  logic         ser_clk,
  input  logic         ser_data,
  input  logic         ser_stb,
  output logic [3:0]   blank_time,
  output logic [9:0]   off_time,
  output logic [7:0]   fast_decay,
  output logic [1:0]   sync_passive,
  output logic [1:0]   int_slow,
  output logic [1:0]   ext_slow,
  output logic [1:0]   phase,
  output logic [7:0]   dac_code,
  output logic         tmon_route,
  output logic         cpump_off
);
  logic sclk_s, sdat_s, stb_s, sleep_s;
  logic wipe;
  logic commit_v;
  logic [ADDR_W-1:0]    commit_addr;
  logic [PAYLOAD_W-1:0] commit_data;
  timing_t [NUM_BR-1:0] timing;
  bctrl_t  [NUM_BR-1:0] bctrl;
  logic    [MISC_W-1:0] misc;

  motor_cfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_clk (
    .clk(clk), .rst_n(rst_n), .d(ser_clk), .q(sclk_s));
  motor_cfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_dat (
    .clk(clk), .rst_n(rst_n), .d(ser_data), .q(sdat_s));
  motor_cfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_stb (
    .clk(clk), .rst_n(rst_n), .d(ser_stb), .q(stb_s));
  motor_cfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_slp (
    .clk(clk), .rst_n(rst_n), .d(sleep_n), .q(sleep_s));

  // Any clear source returns the configuration to defaults; clear beats commit.
  assign wipe = ~sleep_s | uvlo | ocp_fault;

  motor_cfg_shift u_shift (
    .clk(clk), .rst_n(rst_n), .clr(wipe),
    .sclk_s(sclk_s), .sdat_s(sdat_s), .stb_s(stb_s),
    .commit_v(commit_v), .commit_addr(commit_addr), .commit_data(commit_data));

  motor_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .clr(wipe),
    .wr_v(commit_v), .wr_addr(commit_addr), .wr_data(commit_data),
    .timing_o(timing), .bctrl_o(bctrl), .misc_o(misc));

  for (genvar i = 0; i < NUM_BR; i++) begin : g_out
    assign blank_time[2*i +: 2]  = timing[i].blank;
    assign off_time[5*i +: 5]    = timing[i].off_time;
    assign fast_decay[4*i +: 4]  = timing[i].fast_decay;
    assign sync_passive[i]       = timing[i].sync_passive;
    assign int_slow[i]           = bctrl[i].int_slow;
    assign ext_slow[i]           = bctrl[i].ext_slow;
    assign phase[i]              = bctrl[i].phase;
    assign dac_code[4*i +: 4]    = bctrl[i].dac;
  end

  assign tmon_route = misc[0];
  assign cpump_off  = misc[1];
endmodule

// File: rtl/motor_cfg_chk.sv
module motor_cfg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       uvlo,
  input logic       ocp_fault,
  input logic       wipe,
  input logic       commit_v,
  input logic [1:0] commit_addr,
  input logic [3:0] blank_time,
  input logic [9:0] off_time,
  input logic [7:0] fast_decay,
  input logic [1:0] sync_passive,
  input logic [1:0] int_slow,
  input logic [1:0] ext_slow,
  input logic [1:0] phase,
  input logic [7:0] dac_code,
  input logic       tmon_route,
  input logic       cpump_off
);
  logic at_default;
  assign at_default = (off_time == 10'b10000_10000) && (blank_time == '0) &&
                      (fast_decay == '0) && (sync_passive == '0) &&
                      (int_slow == '0) && (ext_slow == '0) && (phase == '0) &&
                      (dac_code == '0) && !tmon_route && !cpump_off;

  assert_wipe_defaults_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wipe |=> at_default) else $error("clear did not restore defaults");

  assert_uvlo_defaults_R8: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo |=> at_default) else $error("undervoltage did not restore defaults");

  assert_ocp_defaults_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ocp_fault |=> at_default) else $error("overcurrent did not restore defaults");

  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit_v && !wipe) |=> $stable({blank_time, off_time, fast_decay, sync_passive,
                                      int_slow, ext_slow, phase, dac_code,
                                      tmon_route, cpump_off}))
    else $error("outputs moved without commit");

  assert_isolation_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_v && commit_addr != 2'd2 && !wipe) |=> $stable({int_slow, ext_slow, phase, dac_code}))
    else $error("control outputs moved on write to another word");
endmodule

bind motor_cfg_port motor_cfg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .uvlo(uvlo), .ocp_fault(ocp_fault),
  .wipe(wipe), .commit_v(commit_v), .commit_addr(commit_addr),
  .blank_time(blank_time), .off_time(off_time), .fast_decay(fast_decay),
  .sync_passive(sync_passive), .int_slow(int_slow), .ext_slow(ext_slow),
  .phase(phase), .dac_code(dac_code), .tmon_route(tmon_route),
  .cpump_off(cpump_off));

// File: tb/motor_cfg_port_tb.sv
module motor_cfg_port_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, sleep_n = 1'b1, uvlo = 1'b0, ocp_fault = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_stb = 1'b0;
  logic [3:0] blank_time; logic [9:0] off_time; logic [7:0] fast_decay;
  logic [1:0] sync_passive, int_slow, ext_slow, phase; logic [7:0] dac_code;
  logic tmon_route, cpump_off;

  motor_cfg_port u_dut (.*);

  logic [39:0] got;
  assign got = {blank_time, off_time, fast_decay, sync_passive, int_slow,
                ext_slow, phase, dac_code, tmon_route, cpump_off};

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // Reference model of the four words (requirement-level field layout).
  logic [11:0] m_t0, m_t1; logic [13:0] m_c; logic [1:0] m_m;

  task automatic model_reset();
    m_t0 = 12'h040; m_t1 = 12'h040; m_c = '0; m_m = '0;
  endtask

  function automatic logic [39:0] model_vec();
    return {m_t1[1:0], m_t0[1:0], m_t1[6:2], m_t0[6:2], m_t1[10:7], m_t0[10:7],
            m_t1[11], m_t0[11], m_c[0], m_c[7], m_c[1], m_c[8], m_c[2], m_c[9],
            m_c[6:3], m_c[13:10], m_m[0], m_m[1]};
  endfunction

  task automatic model_write(input logic [15:0] w);
    case (w[15:14])
      2'd0: m_t0 = w[11:0];
      2'd1: m_t1 = w[11:0];
      2'd2: m_c  = w[13:0];
      default: m_m = w[1:0];
    endcase
  endtask

  // Scoreboard queues.
  logic [39:0] exp_q[$];
  int          due_q[$];
  string       tag_q[$];

  task automatic expect_after(input string tag, input int dly);
    exp_q.push_back(model_vec());
    due_q.push_back(cyc + dly);
    tag_q.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (due_q.size() > 0 && cyc >= due_q[0]) begin
      logic [39:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      void'(due_q.pop_front());
      n_chk++;
      if (got !== e) begin
        n_fail++;
        $display("FAIL %s actual=%h expected=%h", t, got, e);
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      ser_data = v[i];
      wait_clk(4);
      ser_clk = 1'b1;
      wait_clk(4);
      ser_clk = 1'b0;
    end
  endtask

  task automatic pulse_stb();
    wait_clk(4);
    ser_stb = 1'b1;
    wait_clk(8);
    ser_stb = 1'b0;
    wait_clk(4);
  endtask

  task automatic frame(input logic [15:0] w, input string tag);
    send_bits({16'h0, w}, 16);
    pulse_stb();
    model_write(w);
    expect_after(tag, 1);
    wait_clk(2);
  endtask

  task automatic clear_pulse(input int which);
    case (which)
      0: sleep_n = 1'b0;
      1: uvlo = 1'b1;
      default: ocp_fault = 1'b1;
    endcase
    wait_clk(1);
    sleep_n = 1'b1; uvlo = 1'b0; ocp_fault = 1'b0;
    model_reset();
    wait_clk(4);
  endtask

  initial begin
    model_reset();
    wait_clk(10);
    rst_n = 1'b1;
    wait_clk(5);
    expect_after("R6 reset defaults", 0);
    wait_clk(2);

    // R2: fully shifted but not yet strobed -> unchanged; commit latency bound.
    send_bits({16'h0, 16'h0A5B}, 16);
    expect_after("R2 no change before strobe", 0);
    wait_clk(2);
    wait_clk(4);
    ser_stb = 1'b1;
    model_write(16'h0A5B);
    expect_after("R2 commit within 6 cycles (R1 R4 word0)", 6);
    wait_clk(8);
    ser_stb = 1'b0;
    wait_clk(4);

    frame(16'h73C6, "R3 R4 word1 bridge2 timing");
    frame(16'hAD69, "R5 control word");
    frame(16'hFFFE, "R5 misc word cpump");
    frame(16'hC001, "R5 misc word tmon");
    frame(16'h08F1, "R3 word0 rewrite leaves others");

    // R10: short and long frames are dropped.
    send_bits({16'h0, 16'h0123}, 15);
    pulse_stb();
    expect_after("R10 15-bit frame ignored", 1);
    wait_clk(2);
    send_bits({15'h0, 17'h10FFF}, 17);
    pulse_stb();
    expect_after("R10 17-bit frame ignored", 1);
    wait_clk(2);

    // R11: clock edges under a high strobe do not count.
    ser_stb = 1'b1;
    wait_clk(8);
    for (int k = 0; k < 3; k++) begin
      ser_clk = 1'b1; wait_clk(4); ser_clk = 1'b0; wait_clk(4);
    end
    ser_stb = 1'b0;
    wait_clk(4);
    frame(16'h1123, "R11 edges under strobe ignored");

    // R12: long idle, nothing moves.
    wait_clk(50);
    expect_after("R12 hold while idle", 0);
    wait_clk(2);

    // R7: sleep clears, and a frame split by sleep is dropped.
    clear_pulse(0);
    expect_after("R7 sleep restores defaults", 0);
    wait_clk(2);
    send_bits({24'h0, 8'h8F}, 8);
    clear_pulse(0);
    send_bits({24'h0, 8'hFF}, 8);
    pulse_stb();
    expect_after("R7 partial frame dropped by sleep", 1);
    wait_clk(2);

    // R8: undervoltage clear.
    frame(16'hBFFF, "R5 control word all ones");
    clear_pulse(1);
    expect_after("R8 undervoltage restores defaults", 0);
    wait_clk(2);

    // R9: overcurrent clear.
    frame(16'h0FFF, "R4 word0 all ones");
    frame(16'hC003, "R5 misc both flags");
    clear_pulse(2);
    expect_after("R9 overcurrent restores defaults", 0);
    wait_clk(2);

    frame(16'h4555, "R1 write after clear");

    while (due_q.size() > 0) wait_clk(1);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R2 watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule